// File: doc/BRIEF.md
# Read-Window DQ Termination Timer

This block sits in the controller of a shared bidirectional data bus to an SRAM that reads and writes bursts of two beats. It runs on a tick at twice the memory clock rate, so each tick is one half cycle. Read and write commands arrive on the memory-clock boundary and pass through short history shift registers. From these histories the block works out, half cycle by half cycle, when read data is on the bus. It then derives three sets of controls from that timing. The first is the memory-side termination enables (pull-up and pull-down). The second is the controller's own termination window. The third is the controller's choice between driving write data and holding the bus low.

The read latency is chosen at run time, either four or five half cycles after the command. Two memory-side styles are supported. In the joint style, both pull-up and pull-down are withdrawn over a window that extends one half cycle on each side of the data. In the split style, only the pull-up uses that widened window, and the pull-down is withdrawn only during the beats. The controller's termination window opens one half cycle before the first read beat and closes three half cycles after the last one. A parameter can shift it later by whole half cycles. All outputs are registered on the tick.

Top module: `odt_dq_term_timer`

## Requirements
- R1: While rst_ni is low, mem_pu_en_o, mem_pd_en_o, ctl_drive_wr_o, ctl_term_en_o, rd_beat_o and cyc_phase_o are 0, and ctl_drive_low_o is 1.
- R2: After reset, cyc_phase_o toggles every tick and is 1 after the first edge. rd_cmd_i and wr_cmd_i are taken only at an edge where cyc_phase_o was 0 beforehand. A command presented at any other edge has no effect on any output.
- R3: With lat_sel_i = 0 (latency 4 half cycles) or 1 (5 half cycles), a read taken at edge e makes rd_beat_o high after edges e+L and e+L+1.
- R4: With style_sel_i = 0 (joint) and odt_en_i = 1, mem_pu_en_o and mem_pd_en_o are both low after edges e+L-1 through e+L+2 for any read taken at e, and high otherwise.
- R5: With style_sel_i = 1 (split) and odt_en_i = 1, mem_pu_en_o follows the R4 window. mem_pd_en_o is low only after edges e+L and e+L+1.
- R6: When odt_en_i is 0 at an edge, mem_pu_en_o and mem_pd_en_o are low after that edge.
- R7: Reads whose windows overlap or touch form one continuous window, and the enables do not re-assert between them.
- R8: A write taken at edge w makes ctl_drive_wr_o high after edges w+WR_LAT and w+WR_LAT+1 (WR_LAT defaults to 2).
- R9: ctl_term_en_o is high after edges e+L-1+CTL_SHIFT through e+L+4+CTL_SHIFT for a read taken at e (CTL_SHIFT defaults to 0), except where write data is driven.
- R10: Exactly one of ctl_drive_low_o, ctl_drive_wr_o and ctl_term_en_o is high at any time. Write drive takes precedence, and the bus is driven low whenever neither other control is high.
- R11: A write beat that falls inside a controller termination window is a usage error and is flagged by an assertion. ctl_term_en_o and ctl_drive_wr_o are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-cycle tick clock (twice the memory clock rate) |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously to clk_i |
| odt_en_i | input | 1 | Global memory termination enable |
| lat_sel_i | input | 1 | Read latency select: 0 = 4 half cycles, 1 = 5 half cycles |
| style_sel_i | input | 1 | Memory termination style: 0 = joint, 1 = split |
| rd_cmd_i | input | 1 | Read command, sampled on command edges |
| wr_cmd_i | input | 1 | Write command, sampled on command edges |
| mem_pu_en_o | output | 1 | Memory-side DQ pull-up enable |
| mem_pd_en_o | output | 1 | Memory-side DQ pull-down enable |
| ctl_drive_low_o | output | 1 | Controller drives DQ low |
| ctl_drive_wr_o | output | 1 | Controller drives write data |
| ctl_term_en_o | output | 1 | Controller-side DQ termination enable |
| rd_beat_o | output | 1 | Read data occupies the DQ bus |
| cyc_phase_o | output | 1 | Half-cycle phase; 0 means the next edge takes commands |

## Verification
The checker looks at every cycle. It confirms that the phase toggles, that exactly one controller control is high, and that a low global enable turns both memory enables off. It also checks that a read beat always has the memory pull-up off, that a withdrawn pull-down implies a withdrawn pull-up, that the joint style keeps the two enables equal, and that no write beat falls inside a controller termination window. The exact placement of each window relative to its command cannot be checked this way and needs the bench's scenarios. The same holds for the two latencies, the merging of back-to-back reads, the split-style pull-down and the ignored off-phase commands.

// File: rtl/odt_win_pkg.sv
package odt_win_pkg;

  // read latency choices, in half cycles after the command edge
  localparam int LAT_HALF_MIN = 4;
  localparam int LAT_HALF_MAX = 5;

  // window margins around the two read beats, in half cycles
  localparam int PRE_HALF      = 1;  // before the first beat
  localparam int POST_MEM_HALF = 1;  // memory side, after the last beat
  localparam int POST_CTL_HALF = 3;  // controller side, after the last beat

  localparam int BURST_BEATS = 2;

  typedef enum logic {
    STY_JOINT = 1'b0,
    STY_SPLIT = 1'b1
  } term_style_e;

endpackage

// File: rtl/odt_phase_gate.sv
module odt_phase_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_cmd_i,
  input  logic wr_cmd_i,
  output logic rd_take_o,
  output logic wr_take_o,
  output logic phase_o
);

  logic ph_q;
  logic ph_d;

  always_comb begin
    ph_d      = ~ph_q;
    rd_take_o = rd_cmd_i & ~ph_q;
    // a read wins when both arrive in the same slot
    wr_take_o = wr_cmd_i & ~ph_q & ~rd_cmd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ph_d;
  end

  assign phase_o = ph_q;

endmodule

// File: rtl/odt_cmd_hist.sv
module odt_cmd_hist #(
  parameter int DEPTH = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  output logic [DEPTH:0]   hist_o
);

  logic [DEPTH-1:0] hist_q;
  logic [DEPTH-1:0] hist_d;

  always_comb begin
    hist_o = {hist_q, take_i};
    hist_d = hist_o[DEPTH-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= hist_d;
  end

endmodule

// File: rtl/odt_win_decode.sv
module odt_win_decode
  import odt_win_pkg::*;
#(
  parameter int RD_DEPTH  = 9,
  parameter int WR_DEPTH  = 3,
  parameter int CTL_SHIFT = 0,
  parameter int WR_LAT    = 2
) (
  input  logic [RD_DEPTH:0] rd_hist_i,
  input  logic [WR_DEPTH:0] wr_hist_i,
  input  logic              lat_sel_i,
  output logic              beat_o,
  output logic              wide_o,
  output logic              ctl_win_o,
  output logic              wr_beat_o
);

  function automatic logic [RD_DEPTH:0] span_mask(input int lo, input int hi);
    logic [RD_DEPTH:0] m;
    m = '0;
    for (int i = 0; i <= RD_DEPTH; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction

  logic [1:0] beat_l;
  logic [1:0] wide_l;
  logic [1:0] ctl_l;

  for (genvar g = 0; g < 2; g++) begin : g_lat
    localparam int LAT  = LAT_HALF_MIN + g;
    localparam int LAST = LAT + BURST_BEATS - 1;
    localparam logic [RD_DEPTH:0] M_BEAT = span_mask(LAT, LAST);
    localparam logic [RD_DEPTH:0] M_WIDE = span_mask(LAT - PRE_HALF, LAST + POST_MEM_HALF);
    localparam logic [RD_DEPTH:0] M_CTL  = span_mask(LAT - PRE_HALF + CTL_SHIFT,
                                                     LAST + POST_CTL_HALF + CTL_SHIFT);
    assign beat_l[g] = |(rd_hist_i & M_BEAT);
    assign wide_l[g] = |(rd_hist_i & M_WIDE);
    assign ctl_l[g]  = |(rd_hist_i & M_CTL);
  end

  always_comb begin
    beat_o    = beat_l[lat_sel_i];
    wide_o    = wide_l[lat_sel_i];
    ctl_win_o = ctl_l[lat_sel_i];
    wr_beat_o = |wr_hist_i[WR_LAT +: BURST_BEATS];
  end

endmodule

// File: rtl/odt_dq_term_timer.sv
module odt_dq_term_timer
  import odt_win_pkg::*;
#(
  parameter int CTL_SHIFT = 0,
  parameter int WR_LAT    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic odt_en_i,
  input  logic lat_sel_i,
  input  logic style_sel_i,
  input  logic rd_cmd_i,
  input  logic wr_cmd_i,
  output logic mem_pu_en_o,
  output logic mem_pd_en_o,
  output logic ctl_drive_low_o,
  output logic ctl_drive_wr_o,
  output logic ctl_term_en_o,
  output logic rd_beat_o,
  output logic cyc_phase_o
);

  localparam int RD_DEPTH = LAT_HALF_MAX + BURST_BEATS - 1 + POST_CTL_HALF + CTL_SHIFT;
  localparam int WR_DEPTH = WR_LAT + BURST_BEATS - 1;

  logic                rd_take_w, wr_take_w;
  logic [RD_DEPTH:0]   rd_hist_w;
  logic [WR_DEPTH:0]   wr_hist_w;
  logic                beat_w, wide_w, ctl_win_w, wr_beat_w;
  term_style_e         style_w;

  odt_phase_gate u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_cmd_i  (rd_cmd_i),
    .wr_cmd_i  (wr_cmd_i),
    .rd_take_o (rd_take_w),
    .wr_take_o (wr_take_w),
    .phase_o   (cyc_phase_o)
  );

  odt_cmd_hist #(.DEPTH(RD_DEPTH)) u_rd_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (rd_take_w),
    .hist_o (rd_hist_w)
  );

  odt_cmd_hist #(.DEPTH(WR_DEPTH)) u_wr_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (wr_take_w),
    .hist_o (wr_hist_w)
  );

  odt_win_decode #(
    .RD_DEPTH  (RD_DEPTH),
    .WR_DEPTH  (WR_DEPTH),
    .CTL_SHIFT (CTL_SHIFT),
    .WR_LAT    (WR_LAT)
  ) u_dec (
    .rd_hist_i (rd_hist_w),
    .wr_hist_i (wr_hist_w),
    .lat_sel_i (lat_sel_i),
    .beat_o    (beat_w),
    .wide_o    (wide_w),
    .ctl_win_o (ctl_win_w),
    .wr_beat_o (wr_beat_w)
  );

  assign style_w = term_style_e'(style_sel_i);

  logic pu_d, pd_d, low_d, wr_d, term_d, beat_d;
  logic pu_q, pd_q, low_q, wr_q, term_q, beat_q;

  always_comb begin
    pu_d   = odt_en_i & ~wide_w;
    pd_d   = odt_en_i & ~((style_w == STY_SPLIT) ? beat_w : wide_w);
    wr_d   = wr_beat_w;
    term_d = ctl_win_w & ~wr_beat_w;
    low_d  = ~wr_beat_w & ~ctl_win_w;
    beat_d = beat_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pu_q   <= 1'b0;
      pd_q   <= 1'b0;
      low_q  <= 1'b1;
      wr_q   <= 1'b0;
      term_q <= 1'b0;
      beat_q <= 1'b0;
    end else begin
      pu_q   <= pu_d;
      pd_q   <= pd_d;
      low_q  <= low_d;
      wr_q   <= wr_d;
      term_q <= term_d;
      beat_q <= beat_d;
    end
  end

  assign mem_pu_en_o     = pu_q;
  assign mem_pd_en_o     = pd_q;
  assign ctl_drive_low_o = low_q;
  assign ctl_drive_wr_o  = wr_q;
  assign ctl_term_en_o   = term_q;
  assign rd_beat_o       = beat_q;

endmodule

// File: rtl/odt_win_chk.sv
module odt_win_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic odt_en_i,
  input logic style_sel_i,
  input logic mem_pu_en_i,
  input logic mem_pd_en_i,
  input logic ctl_drive_low_i,
  input logic ctl_drive_wr_i,
  input logic ctl_term_en_i,
  input logic rd_beat_i,
  input logic cyc_phase_i,
  input logic ctl_win_i,
  input logic wr_beat_i
);

  // R2: phase alternates every tick
  a_r2_phase_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cyc_phase_i != $past(cyc_phase_i)));

  // R3: a read beat never meets an active memory pull-up
  a_r3_beat_pu_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_beat_i |-> !mem_pu_en_i);

  // R4: joint style keeps both memory enables equal
  a_r4_joint_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(style_sel_i)) |-> (mem_pu_en_i == mem_pd_en_i));

  // R5: pull-down withdrawal is contained in the pull-up window
  a_r5_pd_within_pu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(odt_en_i) && !mem_pd_en_i) |-> !mem_pu_en_i);

  // R6: global enable low forces memory termination off
  a_r6_odt_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !odt_en_i |=> (!mem_pu_en_i && !mem_pd_en_i));

  // R10: exactly one controller-side control
  a_r10_ctl_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ctl_drive_low_i, ctl_drive_wr_i, ctl_term_en_i}) == 1);

  // R11: write data must not fall in a controller termination window
  a_r11_no_wr_in_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_beat_i && ctl_win_i));

endmodule

bind odt_dq_term_timer odt_win_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .odt_en_i        (odt_en_i),
  .style_sel_i     (style_sel_i),
  .mem_pu_en_i     (mem_pu_en_o),
  .mem_pd_en_i     (mem_pd_en_o),
  .ctl_drive_low_i (ctl_drive_low_o),
  .ctl_drive_wr_i  (ctl_drive_wr_o),
  .ctl_term_en_i   (ctl_term_en_o),
  .rd_beat_i       (rd_beat_o),
  .cyc_phase_i     (cyc_phase_o),
  .ctl_win_i       (ctl_win_w),
  .wr_beat_i       (wr_beat_w)
);

// File: tb/odt_dq_term_timer_bench.sv
module odt_dq_term_timer_bench;

  localparam int SHIFT = 0;
  localparam int WLAT  = 2;
  localparam int SZ    = 4096;

  logic clk_i = 1'b0;
  logic rst_ni, odt_en_i, lat_sel_i, style_sel_i, rd_cmd_i, wr_cmd_i;
  logic mem_pu_en_o, mem_pd_en_o, ctl_drive_low_o, ctl_drive_wr_o;
  logic ctl_term_en_o, rd_beat_o, cyc_phase_o;

  always #5 clk_i = ~clk_i;

  odt_dq_term_timer #(.CTL_SHIFT(SHIFT), .WR_LAT(WLAT)) u_odt_dq_term_timer (
    .clk_i, .rst_ni, .odt_en_i, .lat_sel_i, .style_sel_i, .rd_cmd_i, .wr_cmd_i,
    .mem_pu_en_o, .mem_pd_en_o, .ctl_drive_low_o, .ctl_drive_wr_o,
    .ctl_term_en_o, .rd_beat_o, .cyc_phase_o
  );

  bit exp_beat [SZ];
  bit exp_wide [SZ];
  bit exp_ctl  [SZ];
  bit exp_wr   [SZ];
  bit drv_odt  [SZ];
  bit drv_sty  [SZ];
  int e;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  string tag = "";

  task automatic chk(string req, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s at slot %0d: actual=%b expected=%b", req, what, e, act, exp);
    end
  endtask

  function automatic int cur_lat();
    return lat_sel_i ? 5 : 4;
  endfunction

  function automatic bit rd_clash(int s);
    int l = cur_lat();
    for (int k = s + l - 1 + SHIFT; k <= s + l + 4 + SHIFT; k++)
      if (exp_wr[k]) return 1;
    return 0;
  endfunction

  function automatic bit wr_clash(int s);
    return exp_ctl[s + WLAT] || exp_ctl[s + WLAT + 1];
  endfunction

  task automatic check_slot(int s);
    bit b, w, c, wb, o, pu, pd;
    string tp;
    b  = exp_beat[s]; w = exp_wide[s]; c = exp_ctl[s]; wb = exp_wr[s];
    o  = drv_odt[s];
    pu = o & ~w;
    pd = o & ~(drv_sty[s] ? b : w);
    chk((tag != "") ? tag : "R3", rd_beat_o, b, "rd_beat");
    tp = !o ? "R6" : ((tag != "") ? tag : "R4");
    chk(tp, mem_pu_en_o, pu, "mem_pu_en");
    tp = !o ? "R6" : (drv_sty[s] ? "R5" : "R4");
    chk(tp, mem_pd_en_o, pd, "mem_pd_en");
    chk("R8", ctl_drive_wr_o, wb, "ctl_drive_wr");
    chk("R9", ctl_term_en_o, c & ~wb, "ctl_term_en");
    chk("R10", ctl_drive_low_o, ~wb & ~c, "ctl_drive_low");
    chk("R2", cyc_phase_o, (s % 2) == 0, "cyc_phase");
    chk("R11", ctl_term_en_o & ctl_drive_wr_o, 1'b0, "term_and_write");
  endtask

  // one half-cycle slot: drive at negedge, sample at the next negedge
  task automatic slot(bit rd, bit wr, bit odt, bit sty);
    int l = cur_lat();
    if ((e % 2) == 0) begin
      if (rd && rd_clash(e)) rd = 0;
      if (rd) wr = 0;
      if (wr && wr_clash(e)) wr = 0;
      if (rd) begin
        exp_beat[e+l] = 1; exp_beat[e+l+1] = 1;
        for (int k = e + l - 1; k <= e + l + 2; k++) exp_wide[k] = 1;
        for (int k = e + l - 1 + SHIFT; k <= e + l + 4 + SHIFT; k++) exp_ctl[k] = 1;
      end
      if (wr) begin
        exp_wr[e+WLAT] = 1; exp_wr[e+WLAT+1] = 1;
      end
    end
    rd_cmd_i = rd; wr_cmd_i = wr; odt_en_i = odt; style_sel_i = sty;
    drv_odt[e] = odt; drv_sty[e] = sty;
    @(posedge clk_i);
    @(negedge clk_i);
    check_slot(e);
    e++;
  endtask

  task automatic idle(int n, bit sty);
    for (int i = 0; i < n; i++) slot(0, 0, 1, sty);
  endtask

  task automatic align(bit sty);
    if ((e % 2) != 0) slot(0, 0, 1, sty);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0D7_5EED));
    rst_ni = 0; odt_en_i = 1; lat_sel_i = 0; style_sel_i = 0;
    rd_cmd_i = 0; wr_cmd_i = 0; e = 0;
    repeat (3) @(negedge clk_i);
    // R1 reset values
    chk("R1", mem_pu_en_o, 1'b0, "mem_pu_en");
    chk("R1", mem_pd_en_o, 1'b0, "mem_pd_en");
    chk("R1", ctl_drive_low_o, 1'b1, "ctl_drive_low");
    chk("R1", ctl_drive_wr_o, 1'b0, "ctl_drive_wr");
    chk("R1", ctl_term_en_o, 1'b0, "ctl_term_en");
    chk("R1", rd_beat_o, 1'b0, "rd_beat");
    chk("R1", cyc_phase_o, 1'b0, "cyc_phase");
    rst_ni = 1;

    // single read, latency 4, joint style (R3, R4, R9)
    slot(1, 0, 1, 0); idle(14, 0);
    // single read, latency 5, split style (R3, R5)
    lat_sel_i = 1;
    align(1); slot(1, 0, 1, 1); idle(15, 1);
    lat_sel_i = 0;
    // R7 back-to-back reads merge
    tag = "R7";
    align(0);
    for (int i = 0; i < 4; i++) begin slot(1, 0, 1, 0); slot(0, 0, 1, 0); end
    idle(14, 0);
    // R2 commands on the off phase are ignored
    tag = "R2";
    align(0); slot(0, 0, 1, 0); slot(1, 0, 1, 0); slot(0, 0, 1, 0); slot(0, 1, 1, 0);
    idle(14, 0);
    tag = "";
    // R6 global enable off across a read
    align(0); slot(1, 0, 0, 0);
    for (int i = 0; i < 10; i++) slot(0, 0, 0, 0);
    idle(6, 0);
    // R8 write then read next cycle; read then write at minimum spacing
    align(0); slot(0, 1, 1, 1); slot(0, 0, 1, 1); slot(1, 0, 1, 1);
    for (int i = 0; i < 7; i++) slot(0, 0, 1, 1);
    slot(0, 1, 1, 1); idle(16, 1);

    // constrained random segments
    for (int seg = 0; seg < 8; seg++) begin
      bit sty = $urandom % 2;
      lat_sel_i = $urandom % 2;
      for (int i = 0; i < 300; i++) begin
        int r = $urandom % 8;
        bit odt = ($urandom % 8) != 0;
        if (($urandom % 16) == 0) sty = ~sty;
        slot(r < 3, (r == 3) || (r == 4), odt, sty);
      end
      idle(16, sty);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule